// File: doc/BRIEF.md
# Index Register Memory Transfer Sequencer

This block executes the index-pointer and bulk memory instructions of a small 8-bit processor. When started with a 16-bit opcode whose top nibble is 0xF, the low byte picks one of four operations: add a general register Vx to the index pointer I, write the three decimal digits of Vx to memory, copy registers V0..Vx out to memory, or fill V0..Vx from memory. The register file, the index pointer and the byte memory all live outside the block. The sequencer drives their read and write ports directly, one memory byte per cycle.

The register file and memory are read combinationally: the read data must be valid in the same cycle as the address. I is 16 bits wide so that an add past 0xFFF can be seen. Memory addresses use only the low 12 bits of I plus a step count, so they wrap within 4 KB. Bulk copies leave I untouched. A one-cycle done pulse follows the final write. An opcode outside the group, or an unknown low byte, gives a one-cycle illegal pulse and writes nothing.

Top module: `idx_xfer_seq`

## Requirements
- R1: After reset, busy_o, done_o, illegal_o, mem_we_o, rf_we_o and idx_we_o are all low.
- R2: Opcode 0xFx1E writes I+Vx (16-bit sum) to I. In the same single cycle it writes register 15 with 1 if the new I exceeds 0xFFF, else 0. The operand is read before the flag is written, so it is the old value even when x is 15.
- R3: Opcode 0xFx33 writes the hundreds, tens and ones digits of Vx (binary values 0..9) to addresses I, I+1 and I+2, in three cycles.
- R4: Opcode 0xFx55 writes V0..Vx to addresses I..I+x in ascending order, one per cycle. Bytes beyond I+x are untouched.
- R5: Opcode 0xFx65 loads addresses I..I+x into V0..Vx, one per cycle. Registers above x are untouched.
- R6: The decimal split, store and load operations never write I.
- R7: Memory addresses are the low 12 bits of I plus the step index, taken modulo 4096.
- R8: busy_o is high for exactly N cycles, where N is 1 for the add, 3 for the split and x+1 for store or load. done_o is a one-cycle pulse in the cycle after the last transfer.
- R9: A start with opcode bits 15:12 other than 0xF, or with a low byte other than 0x1E/0x33/0x55/0x65, raises illegal_o for one cycle. It starts nothing and writes nothing.
- R10: A start_i while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch the opcode on opcode_i (taken only when idle) |
| opcode_i | input | 16 | Instruction word |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse after the last transfer |
| illegal_o | output | 1 | One-cycle pulse for an unsupported opcode |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 8 | Register file read data (same cycle) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 8 | Register file write data |
| idx_i | input | 16 | Current index pointer I |
| idx_we_o | output | 1 | Index pointer write enable |
| idx_wdata_o | output | 16 | New index pointer value |
| mem_addr_o | output | 12 | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data (same cycle) |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
On every cycle, the assertions check the following. No port write happens while idle. Memory and register writes never coincide. An I write always comes with a flag write to register 15 whose value matches the new I. done_o and illegal_o are isolated pulses in the right relation to busy_o. Only the bench scenarios can show the data itself: the decimal digits, the order and extent of bulk copies, address wrap at 4 KB, per-operation latency, and starts ignored while busy. The bench checks these against its own register, memory and pointer model.

// File: rtl/idx_xfer_pkg.sv
package idx_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADD, ST_BCD, ST_STORE, ST_LOAD
  } xfer_state_e;

  localparam logic [3:0] GRP_NIB   = 4'hF;
  localparam logic [7:0] SEL_ADD   = 8'h1E;
  localparam logic [7:0] SEL_BCD   = 8'h33;
  localparam logic [7:0] SEL_STORE = 8'h55;
  localparam logic [7:0] SEL_LOAD  = 8'h65;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import idx_xfer_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic [15:0]   opcode_i,
  output xfer_state_e   op_o,
  output logic          legal_o,
  output logic [RW-1:0] x_o
);
  always_comb begin
    op_o = ST_IDLE;
    if (opcode_i[15:12] == GRP_NIB) begin
      case (opcode_i[7:0])
        SEL_ADD:   op_o = ST_ADD;
        SEL_BCD:   op_o = ST_BCD;
        SEL_STORE: op_o = ST_STORE;
        SEL_LOAD:  op_o = ST_LOAD;
        default:   op_o = ST_IDLE;
      endcase
    end
  end

  assign legal_o = (op_o != ST_IDLE);
  assign x_o     = opcode_i[8 +: RW];
endmodule

// File: rtl/bcd_split.sv
// Reciprocal divide by ten (x*205 >> 11), exact for inputs below 1029.
module bcd_split (
  input  logic [7:0] val_i,
  output logic [7:0] hun_o,
  output logic [7:0] ten_o,
  output logic [7:0] one_o
);
  logic [15:0] p1, p2;
  logic [7:0]  q1, q2;

  always_comb begin
    p1    = 16'(val_i) * 16'd205;
    q1    = 8'(p1 >> 11);
    p2    = 16'(q1) * 16'd205;
    q2    = 8'(p2 >> 11);
    hun_o = q2;
    ten_o = q1 - q2 * 8'd10;
    one_o = val_i - q1 * 8'd10;
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import idx_xfer_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          legal_i,
  input  xfer_state_e   op_i,
  input  logic [RW-1:0] x_i,
  output xfer_state_e   state_o,
  output logic [RW-1:0] cnt_o,
  output logic [RW-1:0] x_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o
);
  localparam logic [RW-1:0] BCD_LAST = RW'(2);

  xfer_state_e   state_q;
  logic [RW-1:0] cnt_q, x_q;
  logic          done_q, ill_q, last;

  always_comb begin
    case (state_q)
      ST_ADD:            last = 1'b1;
      ST_BCD:            last = (cnt_q == BCD_LAST);
      ST_STORE, ST_LOAD: last = (cnt_q == x_q);
      default:           last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      x_q     <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          if (legal_i) begin
            state_q <= op_i;
            x_q     <= x_i;
            cnt_q   <= '0;
          end else begin
            ill_q <= 1'b1;
          end
        end
      end else if (last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        done_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign x_o       = x_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/idx_xfer_seq.sv
module idx_xfer_seq
  import idx_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 8,
  parameter int IW   = 16,
  parameter int AW   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [15:0]              opcode_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     illegal_o,
  output logic [$clog2(NREG)-1:0]  rf_raddr_o,
  input  logic [DW-1:0]            rf_rdata_i,
  output logic                     rf_we_o,
  output logic [$clog2(NREG)-1:0]  rf_waddr_o,
  output logic [DW-1:0]            rf_wdata_o,
  input  logic [IW-1:0]            idx_i,
  output logic                     idx_we_o,
  output logic [IW-1:0]            idx_wdata_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic                     mem_re_o,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic                     mem_we_o,
  output logic [DW-1:0]            mem_wdata_o
);
  localparam int            RW    = $clog2(NREG);
  localparam logic [IW-1:0] LIMIT = IW'((1 << AW) - 1);
  localparam logic [RW-1:0] FLAG  = RW'(NREG - 1);

  xfer_state_e   dec_op, state;
  logic          dec_legal;
  logic [RW-1:0] dec_x, cnt, x_q;
  logic [7:0]    d_hun, d_ten, d_one, digit;
  logic [IW-1:0] sum;

  xfer_decode #(.RW(RW)) u_dec (
    .opcode_i (opcode_i),
    .op_o     (dec_op),
    .legal_o  (dec_legal),
    .x_o      (dec_x)
  );

  xfer_ctrl #(.RW(RW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .legal_i   (dec_legal),
    .op_i      (dec_op),
    .x_i       (dec_x),
    .state_o   (state),
    .cnt_o     (cnt),
    .x_o       (x_q),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  bcd_split u_bcd (
    .val_i (8'(rf_rdata_i)),
    .hun_o (d_hun),
    .ten_o (d_ten),
    .one_o (d_one)
  );

  always_comb begin
    case (cnt)
      RW'(0):  digit = d_hun;
      RW'(1):  digit = d_ten;
      default: digit = d_one;
    endcase
  end

  assign sum = idx_i + IW'(rf_rdata_i);

  assign rf_raddr_o  = (state == ST_STORE) ? cnt : x_q;
  assign mem_addr_o  = idx_i[AW-1:0] + AW'(cnt);
  assign mem_re_o    = (state == ST_LOAD);
  assign mem_we_o    = (state == ST_BCD) || (state == ST_STORE);
  assign mem_wdata_o = (state == ST_STORE) ? rf_rdata_i : DW'(digit);

  assign idx_we_o    = (state == ST_ADD);
  assign idx_wdata_o = sum;

  // Overflow flag goes to the last register during the add cycle
  assign rf_we_o     = (state == ST_ADD) || (state == ST_LOAD);
  assign rf_waddr_o  = (state == ST_ADD) ? FLAG : cnt;
  assign rf_wdata_o  = (state == ST_ADD) ? DW'(sum > LIMIT) : mem_rdata_i;
endmodule

// File: rtl/idx_xfer_chk.sv
module idx_xfer_chk #(
  parameter int DW = 8,
  parameter int IW = 16,
  parameter int AW = 12,
  parameter int RW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          illegal_o,
  input logic          rf_we_o,
  input logic [RW-1:0] rf_waddr_o,
  input logic [DW-1:0] rf_wdata_o,
  input logic          idx_we_o,
  input logic [IW-1:0] idx_wdata_o,
  input logic          mem_we_o
);
  localparam logic [IW-1:0] LIMIT = IW'((1 << AW) - 1);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || rf_we_o || idx_we_o)); // R9
  AST_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && rf_we_o)); // R4
  AST_IDX_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_o |-> (rf_we_o && rf_waddr_o == RW'(15))); // R2
  AST_FLAG_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_o |-> (rf_wdata_o == DW'(idx_wdata_o > LIMIT))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o); // R8
  AST_ILLEGAL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o && !done_o); // R9
  AST_ILLEGAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o); // R9
endmodule

bind idx_xfer_seq idx_xfer_chk #(.DW(DW), .IW(IW), .AW(AW), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .rf_wdata_o  (rf_wdata_o),
  .idx_we_o    (idx_we_o),
  .idx_wdata_o (idx_wdata_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/sim_idx_xfer_seq.sv
`timescale 1ns/1ps
module sim_idx_xfer_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic        busy, done, illegal;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, rf_wdata, mem_rdata, mem_wdata;
  logic        rf_we, idx_we, mem_re, mem_we;
  logic [15:0] idx, idx_wdata;
  logic [11:0] mem_addr;

  logic [7:0]  regs [16];
  logic [7:0]  mem  [4096];

  int checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  idx_xfer_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .busy_o(busy), .done_o(done), .illegal_o(illegal),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .idx_i(idx), .idx_we_o(idx_we), .idx_wdata_o(idx_wdata),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we)  regs[rf_waddr] <= rf_wdata;
    if (mem_we) mem[mem_addr]  <= mem_wdata;
    if (idx_we) idx            <= idx_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Launch an opcode; returns negedges from capture until done (or illegal) seen
  task automatic run_op(input logic [15:0] op, output int lat, output logic saw_ill);
    @(negedge clk); start = 1'b1; opcode = op;
    @(negedge clk); start = 1'b0;
    lat = 1; saw_ill = illegal;
    while (!done && !saw_ill && lat < 40) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);   chk("R1 done", done, 0);
    chk("R1 illegal", illegal, 0);
    chk("R1 writes", {mem_we, rf_we, idx_we}, 0);
  endtask

  task automatic t_add();
    int lat; logic ill;
    idx = 16'h0F00; regs[3] = 8'h10; regs[15] = 8'h55;
    run_op(16'hF31E, lat, ill);
    chk("R2 sum", idx, 16'h0F10); chk("R2 flag clear", regs[15], 0);
    chk("R8 add latency", lat, 2);
    idx = 16'h0FFF; regs[5] = 8'h01;
    run_op(16'hF51E, lat, ill);
    chk("R2 sum over", idx, 16'h1000); chk("R2 flag set", regs[15], 1);
    idx = 16'h0FF0; regs[15] = 8'h80;
    run_op(16'hFF1E, lat, ill);
    chk("R2 x15 sum", idx, 16'h1070); chk("R2 x15 flag", regs[15], 1);
  endtask

  task automatic t_bcd();
    int lat; logic ill;
    idx = 16'h0300; regs[2] = 8'd255; mem[12'h303] = 8'hAA;
    run_op(16'hF233, lat, ill);
    chk("R3 hun 255", mem[12'h300], 2); chk("R3 ten 255", mem[12'h301], 5);
    chk("R3 one 255", mem[12'h302], 5); chk("R3 beyond", mem[12'h303], 8'hAA);
    chk("R6 idx bcd", idx, 16'h0300); chk("R8 bcd latency", lat, 4);
    regs[7] = 8'd7;
    run_op(16'hF733, lat, ill);
    chk("R3 digits 7", {mem[12'h300], mem[12'h301], mem[12'h302]}, 24'h000007);
    regs[1] = 8'd100;
    run_op(16'hF133, lat, ill);
    chk("R3 digits 100", {mem[12'h300], mem[12'h301], mem[12'h302]}, 24'h010000);
    regs[4] = 8'd199;
    run_op(16'hF433, lat, ill);
    chk("R3 digits 199", {mem[12'h300], mem[12'h301], mem[12'h302]}, 24'h010909);
  endtask

  task automatic t_store();
    int lat; logic ill;
    idx = 16'h0400;
    for (int i = 0; i < 16; i++) regs[i] = 8'(8'h30 + i);
    mem[12'h405] = 8'hAA;
    run_op(16'hF455, lat, ill);
    for (int i = 0; i < 5; i++) chk("R4 store byte", mem[12'h400 + i], 8'(8'h30 + i));
    chk("R4 beyond", mem[12'h405], 8'hAA);
    chk("R6 idx store", idx, 16'h0400); chk("R8 store latency", lat, 6);
  endtask

  task automatic t_load();
    int lat; logic ill;
    idx = 16'h0500;
    for (int i = 0; i < 16; i++) mem[12'h500 + i] = 8'(8'hC0 + i);
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    run_op(16'hF265, lat, ill);
    for (int i = 0; i < 3; i++) chk("R5 load reg", regs[i], 8'(8'hC0 + i));
    chk("R5 above x", regs[3], 0); chk("R6 idx load", idx, 16'h0500);
    chk("R8 load latency", lat, 4);
    run_op(16'hFF65, lat, ill);
    chk("R5 load V15", regs[15], 8'hCF); chk("R8 full latency", lat, 17);
  endtask

  task automatic t_wrap();
    int lat; logic ill;
    idx = 16'h0FFE;
    for (int i = 0; i < 4; i++) regs[i] = 8'(8'h70 + i);
    run_op(16'hF355, lat, ill);
    chk("R7 wrap ffe", mem[12'hFFE], 8'h70); chk("R7 wrap fff", mem[12'hFFF], 8'h71);
    chk("R7 wrap 000", mem[12'h000], 8'h72); chk("R7 wrap 001", mem[12'h001], 8'h73);
    chk("R6 idx wrap", idx, 16'h0FFE);
  endtask

  task automatic t_illegal();
    int lat; logic ill;
    idx = 16'h0600; regs[3] = 8'h11; mem[12'h600] = 8'h22;
    run_op(16'hF3AA, lat, ill);
    chk("R9 illegal low byte", ill, 1); chk("R9 no busy", busy, 0);
    @(negedge clk);
    chk("R9 pulse ends", illegal, 0);
    chk("R9 state kept", {idx, regs[3], mem[12'h600]}, {16'h0600, 8'h11, 8'h22});
    run_op(16'hE355, lat, ill);
    chk("R9 illegal group", ill, 1);
    @(negedge clk);
    chk("R9 group kept", {idx, regs[3], mem[12'h600]}, {16'h0600, 8'h11, 8'h22});
  endtask

  task automatic t_busy_start();
    int n = 0;
    idx = 16'h0700; regs[0] = 8'h40;
    @(negedge clk); start = 1'b1; opcode = 16'hF455;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; opcode = 16'hF01E;
    @(negedge clk); start = 1'b0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk("R10 idx kept", idx, 16'h0700); chk("R10 idle after", busy, 0);
    chk("R10 store ran", mem[12'h700], 8'h40);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    idx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add(); t_bcd(); t_store(); t_load(); t_wrap(); t_illegal(); t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog R8 actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule